// File: doc/BRIEF.md
# Two-Port Semaphore Flag Bank

This block holds a bank of one-bit ownership flags that two independent agents, a left port and a right port, use to claim and hand over shared resources. Each port addresses a flag with the low address bits while its semaphore select is high. The port claims the flag by writing 0 on data bit 0 and gives it up by writing 1. A read returns the flag as that port sees it, repeated on every data bit: 0 means "this port holds it", 1 means "not yours".

Each flag is a small state machine with five named states: `FREE`, `L_HELD`, `R_HELD`, `L_HELD_R_WAIT` (left owns, right's claim latched) and `R_HELD_L_WAIT` (right owns, left's claim latched). The transitions are as follows. A claim on `FREE` goes to the claimant's held state, or to `L_HELD_R_WAIT` when both ports claim at once. A claim by the non-owner moves a held state to its matching wait state. A release by the owner moves a held state to `FREE`, or hands the flag straight to the other port when that port claims in the same cycle. A release by the owner in a wait state hands the flag to the waiter. A release by the waiter in a wait state drops its claim and returns to the held state. Releases by both ports in a wait state go to `FREE`. Each port also has a strobe tracker with two states, `STROBE_HIGH` and `STROBE_LOW`, which turns a low-to-high edge of the read/write strobe into a one-cycle write event.

Top module: `sem_flag_bank`

## Requirements
- R1: The flag is selected by address bits [2:0] (eight flags, numbers 0 to 7). Higher address bits have no effect.
- R2: A write happens in the clock cycle in which `x_rd_wr` is sampled 1 after being sampled 0 in the cycle before, with `x_sem_sel`=1 and `x_chip_sel`=0 in that cycle. Only `x_wdata[0]` is used: 0 claims the flag and 1 releases it. The new flag state is visible to reads from the next cycle. Holding the strobe low or high with no edge writes nothing.
- R3: When `x_sem_sel`=1, `x_chip_sel`=0, `x_rd_wr`=1 and `x_out_en`=1 in the same cycle, `x_rvalid`=1 and all 16 bits of `x_rdata` equal 0 if that port owns the flag, and 1 otherwise. Otherwise `x_rvalid`=0 and `x_rdata`=0.
- R4: If both ports claim the same free flag in one cycle, the left port gets it and the right port's claim stays latched.
- R5: A claim on a flag that the other port owns is latched. When the owner releases the flag, ownership passes to the waiting port in that same update.
- R6: A release by a port that only waits withdraws its claim. A release by a port that neither owns nor waits has no effect, and neither does a repeated claim by the owner. Releases by owner and waiter in the same cycle free the flag.
- R7: With `x_chip_sel`=1 and `x_sem_sel`=1 together, the port neither writes nor reads: the flag is unchanged and `x_rvalid`=0.
- R8: After reset every flag is free and no claim is latched, so both ports read 1 on every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_chip_sel | input | 1 | Left memory select; blocks semaphore access when high |
| l_sem_sel | input | 1 | Left semaphore select |
| l_rd_wr | input | 1 | Left strobe: 1 read, rising edge writes |
| l_out_en | input | 1 | Left read enable |
| l_addr | input | 14 | Left address, bits [2:0] pick the flag |
| l_wdata | input | 16 | Left write data, bit 0 used |
| l_rdata | output | 16 | Left read data, flag replicated |
| l_rvalid | output | 1 | Left read is active |
| r_chip_sel | input | 1 | Right memory select; blocks semaphore access when high |
| r_sem_sel | input | 1 | Right semaphore select |
| r_rd_wr | input | 1 | Right strobe: 1 read, rising edge writes |
| r_out_en | input | 1 | Right read enable |
| r_addr | input | 14 | Right address, bits [2:0] pick the flag |
| r_wdata | input | 16 | Right write data, bit 0 used |
| r_rdata | output | 16 | Right read data, flag replicated |
| r_rvalid | output | 1 | Right read is active |

## Verification
Reads depend only on present inputs and flag state, so the bench applies read inputs at a falling edge and samples one time unit later in the same cycle. A write takes two rising edges: the first captures the strobe low, and the second sees it high and updates the flag. The bench raises the strobe at the falling edge between them and drops the select at the following falling edge, and it reads only after that point. All ordering cases (simultaneous claims, hand-over, withdrawal, double release) are therefore checked one cycle after the update edge, never on it.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [2:0] {
        FREE          = 3'd0,
        L_HELD        = 3'd1,
        R_HELD        = 3'd2,
        L_HELD_R_WAIT = 3'd3,
        R_HELD_L_WAIT = 3'd4
    } flag_state_t;

    typedef enum logic {
        STROBE_HIGH = 1'b0,
        STROBE_LOW  = 1'b1
    } strobe_state_t;

endpackage

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 16,
    localparam int SEL_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_sel,
    input  logic                 sem_sel,
    input  logic                 rd_wr,
    input  logic                 out_en,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 wbit,
    input  logic [NUM_FLAGS-1:0] own_vec,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rvalid
);

    strobe_state_t state_q, state_d;
    logic          access_ok;
    logic          wr_evt;
    logic          rd_bit;

    assign access_ok = sem_sel & ~chip_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STROBE_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        wr_evt  = 1'b0;
        unique case (state_q)
            STROBE_HIGH: if (!rd_wr) state_d = STROBE_LOW;
            STROBE_LOW: begin
                if (rd_wr) begin
                    state_d = STROBE_HIGH;
                    wr_evt  = access_ok;
                end
            end
            default: state_d = STROBE_HIGH;
        endcase
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
        assign req_vec[i] = wr_evt && (sel == SEL_W'(i)) && !wbit;
        assign rel_vec[i] = wr_evt && (sel == SEL_W'(i)) &&  wbit;
    end

    always_comb begin
        rvalid = access_ok & rd_wr & out_en;
        rd_bit = ~own_vec[sel];
        rdata  = rvalid ? {DATA_W{rd_bit}} : '0;
    end

    // R1: a write event touches at most one flag
    a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec | rel_vec));

    // R2: writes only on a low-to-high strobe
    a_r2_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_vec | rel_vec)) |-> (rd_wr && !$past(rd_wr)));

    // R7: illegal select combination blocks both directions
    a_r7_illegal_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && sem_sel) |-> (req_vec == '0 && rel_vec == '0 && !rvalid));

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own
);

    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FREE: begin
                if (l_req && r_req) state_d = L_HELD_R_WAIT;
                else if (l_req)     state_d = L_HELD;
                else if (r_req)     state_d = R_HELD;
            end
            L_HELD: begin
                if (l_rel)      state_d = r_req ? R_HELD : FREE;
                else if (r_req) state_d = L_HELD_R_WAIT;
            end
            R_HELD: begin
                if (r_rel)      state_d = l_req ? L_HELD : FREE;
                else if (l_req) state_d = R_HELD_L_WAIT;
            end
            L_HELD_R_WAIT: begin
                if (l_rel && r_rel) state_d = FREE;
                else if (l_rel)     state_d = R_HELD;
                else if (r_rel)     state_d = L_HELD;
            end
            R_HELD_L_WAIT: begin
                if (l_rel && r_rel) state_d = FREE;
                else if (r_rel)     state_d = L_HELD;
                else if (l_rel)     state_d = R_HELD;
            end
            default: state_d = FREE;
        endcase
    end

    always_comb begin
        l_own = (state_q == L_HELD) || (state_q == L_HELD_R_WAIT);
        r_own = (state_q == R_HELD) || (state_q == R_HELD_L_WAIT);
    end

    // R4: simultaneous claims on a free flag favour the left port
    a_r4_left_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FREE && l_req && r_req) |=> (l_own && state_q == L_HELD_R_WAIT));

    // R5: owner release hands the flag to the waiter
    a_r5_handoff_right: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == L_HELD_R_WAIT && l_rel && !r_rel) |=> (r_own && !l_own));

    a_r5_handoff_left: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == R_HELD_L_WAIT && r_rel && !l_rel) |=> (l_own && !r_own));

    // R6: waiter release withdraws the claim and keeps the owner
    a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == L_HELD_R_WAIT && r_rel && !l_rel) |=> (state_q == L_HELD));

    // R6: with no write, ownership does not move
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_req || l_rel || r_req || r_rel) |=> ($stable(l_own) && $stable(r_own)));

endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_chip_sel,
    input  logic              l_sem_sel,
    input  logic              l_rd_wr,
    input  logic              l_out_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_chip_sel,
    input  logic              r_sem_sel,
    input  logic              r_rd_wr,
    input  logic              r_out_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    localparam int SEL_W = $clog2(NUM_FLAGS);

    logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_FLAGS-1:0] l_own, r_own;
    logic                 unused_bits;

    assign unused_bits = ^{l_addr[ADDR_W-1:SEL_W], r_addr[ADDR_W-1:SEL_W],
                           l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    sem_port_ctrl #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (l_chip_sel),
        .sem_sel  (l_sem_sel),
        .rd_wr    (l_rd_wr),
        .out_en   (l_out_en),
        .sel      (l_addr[SEL_W-1:0]),
        .wbit     (l_wdata[0]),
        .own_vec  (l_own),
        .req_vec  (l_req),
        .rel_vec  (l_rel),
        .rdata    (l_rdata),
        .rvalid   (l_rvalid)
    );

    sem_port_ctrl #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_right (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (r_chip_sel),
        .sem_sel  (r_sem_sel),
        .rd_wr    (r_rd_wr),
        .out_en   (r_out_en),
        .sel      (r_addr[SEL_W-1:0]),
        .wbit     (r_wdata[0]),
        .own_vec  (r_own),
        .req_vec  (r_req),
        .rel_vec  (r_rel),
        .rdata    (r_rdata),
        .rvalid   (r_rvalid)
    );

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        sem_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .l_req (l_req[f]),
            .l_rel (l_rel[f]),
            .r_req (r_req[f]),
            .r_rel (r_rel[f]),
            .l_own (l_own[f]),
            .r_own (r_own[f])
        );
    end

    // R8 / exclusivity: no flag is ever owned by both ports
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (l_own & r_own) == '0);

endmodule

// File: tb/sim_sem_flag_bank.sv
module sim_sem_flag_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_cs = 1'b0, l_sem = 1'b0, l_rw = 1'b1, l_oe = 1'b0;
    logic        r_cs = 1'b0, r_sem = 1'b0, r_rw = 1'b1, r_oe = 1'b0;
    logic [13:0] l_addr = '0, r_addr = '0;
    logic [15:0] l_wd = '0, r_wd = '0;
    logic [15:0] l_rd, r_rd;
    logic        l_rv, r_rv;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sem_flag_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .l_chip_sel(l_cs), .l_sem_sel(l_sem), .l_rd_wr(l_rw), .l_out_en(l_oe),
        .l_addr(l_addr), .l_wdata(l_wd), .l_rdata(l_rd), .l_rvalid(l_rv),
        .r_chip_sel(r_cs), .r_sem_sel(r_sem), .r_rd_wr(r_rw), .r_out_en(r_oe),
        .r_addr(r_addr), .r_wdata(r_wd), .r_rdata(r_rd), .r_rvalid(r_rv)
    );

    // {lw, laddr[2:0], ld, rw, raddr[2:0], rd, check_flag[2:0], exp_left, exp_right}
    localparam logic [14:0] VEC [14] = '{
        {1'b1,3'd3,1'b0, 1'b0,3'd0,1'b0, 3'd3,1'b0,1'b1},
        {1'b0,3'd0,1'b0, 1'b1,3'd3,1'b0, 3'd3,1'b0,1'b1},
        {1'b1,3'd3,1'b1, 1'b0,3'd0,1'b0, 3'd3,1'b1,1'b0},
        {1'b0,3'd0,1'b0, 1'b1,3'd3,1'b1, 3'd3,1'b1,1'b1},
        {1'b1,3'd5,1'b0, 1'b1,3'd5,1'b0, 3'd5,1'b0,1'b1},
        {1'b1,3'd5,1'b1, 1'b0,3'd0,1'b0, 3'd5,1'b1,1'b0},
        {1'b1,3'd5,1'b0, 1'b0,3'd0,1'b0, 3'd5,1'b1,1'b0},
        {1'b1,3'd5,1'b1, 1'b0,3'd0,1'b0, 3'd5,1'b1,1'b0},
        {1'b0,3'd0,1'b0, 1'b1,3'd5,1'b1, 3'd5,1'b1,1'b1},
        {1'b1,3'd7,1'b0, 1'b1,3'd0,1'b0, 3'd0,1'b1,1'b0},
        {1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 3'd7,1'b0,1'b1},
        {1'b0,3'd0,1'b0, 1'b1,3'd7,1'b1, 3'd7,1'b0,1'b1},
        {1'b0,3'd0,1'b0, 1'b1,3'd7,1'b0, 3'd7,1'b0,1'b1},
        {1'b1,3'd7,1'b1, 1'b1,3'd7,1'b1, 3'd7,1'b1,1'b1}
    };

    task automatic do_write(input bit lw, input logic [13:0] la, input logic [15:0] ld,
                            input bit rw, input logic [13:0] ra, input logic [15:0] rdv);
        @(negedge clk);
        if (lw) begin l_sem = 1'b1; l_rw = 1'b0; l_addr = la; l_wd = ld; end
        if (rw) begin r_sem = 1'b1; r_rw = 1'b0; r_addr = ra; r_wd = rdv; end
        @(negedge clk);
        l_rw = 1'b1;
        r_rw = 1'b1;
        @(negedge clk);
        l_sem = 1'b0;
        r_sem = 1'b0;
    endtask

    task automatic check_read(input bit left, input int flag, input bit exp, input string tag);
        logic [15:0] got;
        logic        v;
        @(negedge clk);
        if (left) begin l_sem = 1'b1; l_rw = 1'b1; l_oe = 1'b1; l_addr = 14'(flag); end
        else      begin r_sem = 1'b1; r_rw = 1'b1; r_oe = 1'b1; r_addr = 14'(flag); end
        #1;
        got = left ? l_rd : r_rd;
        v   = left ? l_rv : r_rv;
        checks++;
        if (!v || got != {16{exp}}) begin
            errors++;
            $display("FAIL %s %s flag %0d: rvalid=%0b rdata=%h expected rvalid=1 rdata=%h",
                     tag, left ? "left" : "right", flag, v, got, {16{exp}});
        end
        l_sem = 1'b0; l_oe = 1'b0; r_sem = 1'b0; r_oe = 1'b0;
    endtask

    task automatic check_idle_read(input bit left, input string tag);
        logic [15:0] got;
        logic        v;
        #1;
        got = left ? l_rd : r_rd;
        v   = left ? l_rv : r_rv;
        checks++;
        if (v || got != 16'h0000) begin
            errors++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=0 rdata=0000", tag, v, got);
        end
    endtask

    task automatic check_all_free(input string tag);
        for (int f = 0; f < 8; f++) begin
            check_read(1'b1, f, 1'b1, tag);
            check_read(1'b0, f, 1'b1, tag);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: all flags free after reset
        check_all_free("R8 reset");

        // Vector table: R4, R5, R6 orderings
        for (int i = 0; i < 14; i++) begin
            logic [14:0] v;
            v = VEC[i];
            do_write(v[14], {11'h0, v[13:11]}, {15'h0, v[10]},
                     v[9],  {11'h0, v[8:6]},   {15'h0, v[5]});
            check_read(1'b1, int'(v[4:2]), v[1], $sformatf("R4/R5/R6 vec%0d", i));
            check_read(1'b0, int'(v[4:2]), v[0], $sformatf("R4/R5/R6 vec%0d", i));
        end

        // R1: high address bits ignored (0x2A0B selects flag 3)
        do_write(1'b1, 14'h2A0B, 16'h0000, 1'b0, '0, '0);
        check_read(1'b1, 3, 1'b0, "R1 high addr bits");
        check_read(1'b0, 3, 1'b1, "R1 high addr bits");

        // R2: only data bit 0 used (0xFFFE claims flag 6)
        do_write(1'b0, '0, '0, 1'b1, 14'd6, 16'hFFFE);
        check_read(1'b0, 6, 1'b0, "R2 data bit0 only");

        // R2: strobe low without sem at the rising edge writes nothing
        @(negedge clk);
        l_sem = 1'b1; l_rw = 1'b0; l_addr = 14'd2; l_wd = 16'h0000;
        repeat (3) @(negedge clk);
        l_sem = 1'b0;
        @(negedge clk);
        l_rw = 1'b1;
        check_read(1'b1, 2, 1'b1, "R2 no edge no write");

        // R7: chip select with semaphore select blocks the write
        @(negedge clk);
        l_cs = 1'b1;
        do_write(1'b1, 14'd1, 16'h0000, 1'b0, '0, '0);
        l_cs = 1'b0;
        check_read(1'b1, 1, 1'b1, "R7 illegal write ignored");

        // R7: chip select with semaphore select blocks the read
        @(negedge clk);
        r_cs = 1'b1; r_sem = 1'b1; r_rw = 1'b1; r_oe = 1'b1; r_addr = 14'd6;
        check_idle_read(1'b0, "R7 illegal read");
        r_cs = 1'b0; r_sem = 1'b0; r_oe = 1'b0;

        // R3: no output enable means no read
        @(negedge clk);
        l_sem = 1'b1; l_rw = 1'b1; l_oe = 1'b0; l_addr = 14'd3;
        check_idle_read(1'b1, "R3 out_en low");
        l_sem = 1'b0;

        // R8: reset mid-run frees owned flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all_free("R8 reset after use");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule